// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block is one 32-pin bank of general-purpose I/O behind a word-addressed register bus. Software controls each pin's output latch and direction. It can use a plain write, or it can use the atomic set and clear locations, which touch only the bits written as one. A pull-disable register and a peripheral-handover register complete the pad control. When a pin is an input with its pull enabled, the output latch bit chooses pull-up (1) or pull-down (0).

Every pad input passes through a two-flop synchroniser. Each pin then has its own small edge-detection state machine with two states, `LVL_LOW` and `LVL_HIGH`. The transition `RISE` (from `LVL_LOW` to `LVL_HIGH`) happens when the synchronised level is 1 in `LVL_LOW`. The transition `FALL` (from `LVL_HIGH` to `LVL_LOW`) happens when the level is 0 in `LVL_HIGH`. A transition produces an edge pulse only while the pin is an input and not handed to a peripheral.

A rising pulse is captured into the pending status word if the pin's rising-mask bit is set. A falling pulse is captured if the falling-mask bit is set. Software clears pending bits by writing ones to the clear location. The single interrupt output is high while any pending bit is set.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0), the output latch, both masks and the pending status are 0, every pull is enabled (`pad_pull_en` all 1), `alt_sel` is 0 and `irq` is 0.
- R2: A write to word 1 (byte 0x04) sets the latch bits where the data word has ones, a write to word 2 (byte 0x08) clears them, and other latch bits keep their value; a write to word 0 loads the whole latch; `pad_out` shows the latch.
- R3: Word 4 (byte 0x10) holds direction (1 = output) and reads back; writing ones to word 5 (0x14) makes those pins outputs, writing ones to word 6 (0x18) makes them inputs; `pad_oe` = direction AND NOT `alt_sel`.
- R4: Word 3 (byte 0x0C) holds the pull-disable bits; `pad_pull_en` is 1 for a pin that is an input, not pull-disabled and not handed over; `pad_pull_up` equals the latch bit.
- R5: Word 8 (byte 0x20) drives `alt_sel`; a handed-over pin has `pad_oe` 0 and `pad_pull_en` 0 and its edges set no status bit.
- R6: A read of word 0 returns, per pin, the latch bit for outputs and the synchronised pad level for inputs; a pad change reaches the synchroniser output two clocks later.
- R7: With its rising-mask bit (word 16, byte 0x40) set, a rising edge on an input pin sets its bit in the status word (word 18, byte 0x48); an output pin's edges set nothing.
- R8: With its falling-mask bit (word 17, byte 0x44) set, a falling edge sets the status bit; with both masks set either edge sets it; with neither, no edge does.
- R9: Writing ones to word 19 (byte 0x4C) clears the matching status bits; writing all ones clears every pending bit.
- R10: An edge captured in the same cycle that its status bit is cleared leaves the bit set.
- R11: `irq` is 1 exactly while some status bit is 1.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd`; reads of words 1, 2, 5, 6, 19 and of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | PIN_COUNT | Write data |
| bus_rdata | output | PIN_COUNT | Registered read data |
| pad_in | input | PIN_COUNT | Pad input levels (asynchronous) |
| pad_out | output | PIN_COUNT | Output latch to pads |
| pad_oe | output | PIN_COUNT | Pad output enable |
| pad_pull_en | output | PIN_COUNT | Pad pull enable |
| pad_pull_up | output | PIN_COUNT | Pull direction, 1 = up |
| alt_sel | output | PIN_COUNT | Pin handed to peripheral function |
| irq | output | 1 | Any pending edge event |

## Verification
Suppose a pin's edge state machine drifts out of step with the synchronised level. Then a phantom `RISE` or a missed `FALL` shows up as a wrong status bit and as `irq`, two clocks after the pad change plus one capture edge. A corrupted latch or direction bit shows up at `pad_out`, `pad_oe` or `pad_pull_en` one clock after the write that caused it. A wrong clear-versus-capture priority shows up only when a clear write and a synchronised edge coincide in the same cycle, so the bench lines the two up to that exact cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Word indices of the register locations (byte offset / 4); software decodes these.
    typedef enum logic [4:0] {
        RI_DATA      = 5'd0,
        RI_DATA_SET  = 5'd1,
        RI_DATA_CLR  = 5'd2,
        RI_PULL_OFF  = 5'd3,
        RI_DIR       = 5'd4,
        RI_DIR_SET   = 5'd5,
        RI_DIR_CLR   = 5'd6,
        RI_ALT       = 5'd8,
        RI_RISE_MASK = 5'd16,
        RI_FALL_MASK = 5'd17,
        RI_STATUS    = 5'd18,
        RI_CLEAR     = 5'd19
    } reg_idx_e;

    // Level-tracking state of a single pin's edge detector.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_fsm.sv
module gpio_edge_fsm
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic arm_i,
    output logic rise_o,
    output logic fall_o
);
    lvl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // Next state: RISE and FALL transitions follow the level even when disarmed
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // Outputs: edge pulses only while the pin is armed
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise_o = arm_i && lvl_i;
            LVL_HIGH: fall_o = arm_i && !lvl_i;
            default:  ;
        endcase
    end

    // R7: a rising pulse needs the level to have been low one cycle earlier
    assert_rise_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !$past(lvl_i));
    // R8: a falling pulse needs the level to have been high one cycle earlier
    assert_fall_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(lvl_i));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_lvl_i,
    input  logic [PIN_COUNT-1:0] rise_evt_i,
    input  logic [PIN_COUNT-1:0] fall_evt_i,
    output logic [PIN_COUNT-1:0] latch_o,
    output logic [PIN_COUNT-1:0] dir_o,
    output logic [PIN_COUNT-1:0] pull_off_o,
    output logic [PIN_COUNT-1:0] alt_o,
    output logic [PIN_COUNT-1:0] stat_o
);
    logic [PIN_COUNT-1:0] latch_q, dir_q, pull_off_q, alt_q;
    logic [PIN_COUNT-1:0] rmask_q, fmask_q, stat_q, rdata_q;
    logic [PIN_COUNT-1:0] evt, rd_mux;

    function automatic logic at(input logic [ADDR_W-1:0] a, input reg_idx_e r);
        return a == ADDR_W'(r);
    endfunction

    assign evt = (rise_evt_i & rmask_q) | (fall_evt_i & fmask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q    <= '0;
            dir_q      <= '0;
            pull_off_q <= '0;
            alt_q      <= '0;
            rmask_q    <= '0;
            fmask_q    <= '0;
        end else if (bus_wr) begin
            if (at(bus_addr, RI_DATA))      latch_q    <= bus_wdata;
            if (at(bus_addr, RI_DATA_SET))  latch_q    <= latch_q | bus_wdata;
            if (at(bus_addr, RI_DATA_CLR))  latch_q    <= latch_q & ~bus_wdata;
            if (at(bus_addr, RI_PULL_OFF))  pull_off_q <= bus_wdata;
            if (at(bus_addr, RI_DIR))       dir_q      <= bus_wdata;
            if (at(bus_addr, RI_DIR_SET))   dir_q      <= dir_q | bus_wdata;
            if (at(bus_addr, RI_DIR_CLR))   dir_q      <= dir_q & ~bus_wdata;
            if (at(bus_addr, RI_ALT))       alt_q      <= bus_wdata;
            if (at(bus_addr, RI_RISE_MASK)) rmask_q    <= bus_wdata;
            if (at(bus_addr, RI_FALL_MASK)) fmask_q    <= bus_wdata;
        end
    end

    // Pending status: a fresh capture wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (bus_wr && at(bus_addr, RI_CLEAR)) begin
            stat_q <= (stat_q & ~bus_wdata) | evt;
        end else begin
            stat_q <= stat_q | evt;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (at(bus_addr, RI_DATA))      rd_mux = (latch_q & dir_q) | (pad_lvl_i & ~dir_q);
        if (at(bus_addr, RI_PULL_OFF))  rd_mux = pull_off_q;
        if (at(bus_addr, RI_DIR))       rd_mux = dir_q;
        if (at(bus_addr, RI_ALT))       rd_mux = alt_q;
        if (at(bus_addr, RI_RISE_MASK)) rd_mux = rmask_q;
        if (at(bus_addr, RI_FALL_MASK)) rd_mux = fmask_q;
        if (at(bus_addr, RI_STATUS))    rd_mux = stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign latch_o    = latch_q;
    assign dir_o      = dir_q;
    assign pull_off_o = pull_off_q;
    assign alt_o      = alt_q;
    assign stat_o     = stat_q;

    // R2: set location raises every written-one latch bit
    assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(bus_addr, RI_DATA_SET)) |=> ((latch_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R2: clear location drops every written-one latch bit
    assert_latch_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(bus_addr, RI_DATA_CLR)) |=> ((latch_q & $past(bus_wdata)) == '0));
    // R3: direction-set makes written pins outputs
    assert_dir_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(bus_addr, RI_DIR_SET)) |=> ((dir_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R9: cleared bits stay cleared unless a new event arrived
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(bus_addr, RI_CLEAR)) |=> ((stat_q & $past(bus_wdata) & ~$past(evt)) == '0));
    // R10: a captured event is never lost, even under a clear
    assert_event_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
    // R12: write-only set location reads as zero
    assert_wo_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at(bus_addr, RI_DATA_SET)) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PIN_COUNT   = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_pull_en,
    output logic [PIN_COUNT-1:0] pad_pull_up,
    output logic [PIN_COUNT-1:0] alt_sel,
    output logic                 irq
);
    logic [PIN_COUNT-1:0] pad_lvl, rise_evt, fall_evt;
    logic [PIN_COUNT-1:0] latch, dir, pull_off, alt, stat;

    gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_lvl)
    );

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        gpio_edge_fsm u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pad_lvl[p]),
            .arm_i  (!dir[p] && !alt[p]),
            .rise_o (rise_evt[p]),
            .fall_o (fall_evt[p])
        );
    end

    gpio_regfile #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_lvl_i  (pad_lvl),
        .rise_evt_i (rise_evt),
        .fall_evt_i (fall_evt),
        .latch_o    (latch),
        .dir_o      (dir),
        .pull_off_o (pull_off),
        .alt_o      (alt),
        .stat_o     (stat)
    );

    assign pad_out     = latch;
    assign pad_pull_up = latch;
    assign pad_oe      = dir & ~alt;
    assign pad_pull_en = ~dir & ~pull_off & ~alt;
    assign alt_sel     = alt;
    assign irq         = |stat;

    // R5: a handed-over pin never produces an edge pulse
    assert_alt_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_evt | fall_evt) & alt) == '0);
    // R7: an output pin never produces an edge pulse
    assert_out_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_evt | fall_evt) & dir) == '0);
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
    localparam int N = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pull_en, pad_pull_up, alt_sel;
    logic          irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_d = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_edge_bank #(.PIN_COUNT(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .alt_sel(alt_sel), .irq(irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: all tasks start and end on a falling edge
    task automatic wr(input int a, input logic [N-1:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input int a, input logic [N-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare registered read data one cycle after the strobe
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R12: unexpected read data %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pull_en", pad_pull_en, '1);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 alt_sel", alt_sel, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        rd_expect(16, '0, "R1 rise mask");
        rd_expect(18, '0, "R1 status");
        rd_expect(4, '0, "R1 direction");

        // R2 latch set / clear
        wr(1, 32'hF0F0_00FF);
        chk("R2 set", pad_out, 32'hF0F0_00FF);
        wr(2, 32'h0000_00F0);
        chk("R2 clr", pad_out, 32'hF0F0_000F);
        chk("R4 pull_up", pad_pull_up, 32'hF0F0_000F);
        wr(0, 32'h1234_5678);
        chk("R2 load", pad_out, 32'h1234_5678);
        wr(0, 32'hF0F0_000F);

        // R3 direction
        wr(5, 32'h0000_FFFF);
        chk("R3 dir set", pad_oe, 32'h0000_FFFF);
        wr(6, 32'h0000_00F0);
        chk("R3 dir clr", pad_oe, 32'h0000_FF0F);
        rd_expect(4, 32'h0000_FF0F, "R3 dir read");
        chk("R4 pull_en dir", pad_pull_en, 32'hFFFF_00F0);

        // R4 pull disable
        wr(3, 32'hFF00_0000);
        chk("R4 pull_en", pad_pull_en, 32'h00FF_00F0);
        rd_expect(3, 32'hFF00_0000, "R4 pull read");

        // R6 data read mixes latch and synchronised pad
        pad_in = 32'h1234_00A0;
        idle(3);
        rd_expect(0, 32'h1234_00AF, "R6 data view");

        // R12 write-only and unmapped reads
        rd_expect(1, '0, "R12 data-set read");
        rd_expect(2, '0, "R12 data-clr read");
        rd_expect(5, '0, "R12 dir-set read");
        rd_expect(6, '0, "R12 dir-clr read");
        rd_expect(19, '0, "R12 clear read");
        rd_expect(7, '0, "R12 unmapped 7");
        rd_expect(31, '0, "R12 unmapped 31");

        // R5 handover
        wr(8, 32'h0001_0001);
        chk("R5 alt_sel", alt_sel, 32'h0001_0001);
        chk("R5 oe", pad_oe, 32'h0000_FF0E);
        chk("R5 pull_en", pad_pull_en, 32'h00FE_00F0);
        rd_expect(8, 32'h0001_0001, "R5 alt read");

        // Prepare interrupt tests: all inputs, pin 16 handed over
        wr(4, '0);
        wr(8, 32'h0001_0000);
        chk("R5 pull_en all in", pad_pull_en, 32'h00FE_FFFF);
        pad_in = '0;
        idle(4);
        rd_expect(18, '0, "R8 no mask no capture");

        // R7 / R8 masks
        wr(16, 32'h0001_0003);
        wr(17, 32'h0000_0006);
        pad_in = 32'h0001_0007;
        idle(4);
        rd_expect(18, 32'h0000_0003, "R7 rising capture");
        chk("R11 irq high", {31'd0, irq}, 32'd1);
        pad_in = '0;
        idle(4);
        rd_expect(18, 32'h0000_0007, "R8 falling capture");

        // R9 clear
        wr(19, 32'h0000_0001);
        rd_expect(18, 32'h0000_0006, "R9 partial clear");
        chk("R11 irq still high", {31'd0, irq}, 32'd1);
        wr(19, '1);
        rd_expect(18, '0, "R9 clear all");
        chk("R11 irq low", {31'd0, irq}, '0);

        // R10 clear collides with new edge
        wr(16, 32'h0000_0018);
        wr(17, 32'h0000_0008);
        pad_in = 32'h0000_0018;
        idle(4);
        rd_expect(18, 32'h0000_0018, "R10 setup");
        pad_in = 32'h0000_0010;
        idle(2);
        wr(19, 32'h0000_0018);
        rd_expect(18, 32'h0000_0008, "R10 edge kept over clear");
        wr(19, '1);

        // R7 output pin edges ignored
        wr(5, 32'h0000_0008);
        pad_in = 32'h0000_0018;
        idle(4);
        rd_expect(18, '0, "R7 output pin no capture");
        rd_expect(0, 32'h0000_0018, "R6 data view mixed");
        chk("R11 irq idle", {31'd0, irq}, '0);

        idle(2);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R12: actual %0d reads missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule